// File: doc/BRIEF.md
# Pseudo-Random Loopback Traffic Generator and Checker

This block exercises an external 4-bit data path that loops back on itself. Once calibration reports completion, it sends a continuous pseudo-random word stream from a shift-register sequence generator. It also raises a read-enable toward the capture side of the path. The returned words arrive with a `rx_valid` qualifier. Each one is compared against a second, locally running copy of the same sequence. That copy steps only when a word is presented, so no transmit history is stored.

Matching words are counted in a saturating counter. Any mismatch sets a sticky error flag. When the counter reaches the configured run length with no error recorded, a completion flag rises and stays high until reset. The read-enable is delayed by a parameterised number of cycles (`RD_LAT`), so the capture side opens its window when the first word can come back.

Top module: `lfsr_loopback_tg`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `tx_data` is 4'b0001, and `rdata_en`, `correct_cnt`, `done` and `error` are all zero.
- R2: `tx_data` holds 4'b0001 until `cal_done` has been sampled high on a clock edge. After that the stream runs on, and deasserting `cal_done` has no effect on it.
- R3: Once running, `tx_data` changes on every clock edge from value s to {s[2:0], s[3]^s[2]} (polynomial x^4+x^3+1). It starts with 4'b0001 visible for one cycle, repeats every 15 words and never shows zero.
- R4: `rdata_en` first goes high exactly `RD_LAT` cycles after the first cycle in which the stream runs. It then stays high until reset.
- R5: Received words are judged only in cycles with `rx_valid` high. The reference sequence starts at 4'b0001 and advances by one step per such cycle. Cycles with `rx_valid` low change neither `correct_cnt` nor `error`.
- R6: Each judged word equal to the reference raises `correct_cnt` by one on that clock edge. The count saturates at `RUN_LEN` and never wraps.
- R7: A judged word that differs from the reference sets `error` on that edge and leaves `correct_cnt` unchanged. `error` then stays high until reset.
- R8: `done` rises on the edge after `correct_cnt` equals `RUN_LEN` while `error` is low. It then stays high until reset, even if an error arrives later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cal_done | input | 1 | Calibration finished; starts traffic when first seen high |
| tx_data | output | 4 | Pseudo-random word toward the output path |
| rdata_en | output | 1 | Read window enable toward the input path |
| rx_data | input | 4 | Word returned by the loopback |
| rx_valid | input | 1 | `rx_data` holds a returned word this cycle |
| correct_cnt | output | 15 | Saturating count of matching words |
| done | output | 1 | Run length reached without error (sticky) |
| error | output | 1 | At least one mismatch seen (sticky) |

## Verification
The properties assume that the capture side delivers words in transmit order, with none dropped or repeated. They also assume that `rx_valid` stays low until `rdata_en` is high. Only under those conditions do the received words line up with the local reference. The stimulus keeps within this by queuing every transmitted word and popping the oldest one whenever it randomly chooses to present a word during the read window. Faults are introduced only by flipping bits of one chosen delivered word, never by reordering.

// File: rtl/lbtg_pkg.sv
package lbtg_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;
endpackage

// File: rtl/lbtg_lfsr.sv
module lbtg_lfsr #(
  parameter int          W    = 4,
  parameter logic [W-1:0] TAPS = 4'b1100,
  parameter logic [W-1:0] SEED = 4'b0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (step) state_d = {state_q[W-2:0], ^(state_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/lbtg_rd_align.sv
module lbtg_rd_align #(
  parameter int RD_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic rd_en
);
  generate
    if (RD_LAT == 0) begin : g_direct
      assign rd_en = run;
    end else begin : g_chain
      logic [RD_LAT-1:0] dly_q, dly_d;
      if (RD_LAT == 1) begin : g_one
        assign dly_d = run;
      end else begin : g_many
        assign dly_d = {dly_q[RD_LAT-2:0], run};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= dly_d;
      end
      assign rd_en = dly_q[RD_LAT-1];
    end
  endgenerate
endmodule

// File: rtl/lbtg_score.sv
module lbtg_score #(
  parameter int W       = 4,
  parameter int CNT_W   = 15,
  parameter int RUN_LEN = 32767
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [W-1:0]     rx_data,
  input  logic [W-1:0]     ref_data,
  output logic [CNT_W-1:0] cnt,
  output logic             err,
  output logic             fin
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             fin_q, fin_d;
  logic             hit, at_max;

  assign hit    = rx_valid && (rx_data == ref_data);
  assign at_max = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    err_d = err_q;
    fin_d = fin_q | (at_max & ~err_q);
    if (hit && !at_max)          cnt_d = cnt_q + 1'b1;
    if (rx_valid && !hit)        err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
      fin_q <= fin_d;
    end
  end

  assign cnt = cnt_q;
  assign err = err_q;
  assign fin = fin_q;
endmodule

// File: rtl/lfsr_loopback_tg.sv
module lfsr_loopback_tg #(
  parameter int W       = 4,
  parameter int CNT_W   = 15,
  parameter int RUN_LEN = 32767,
  parameter int RD_LAT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_done,
  output logic [W-1:0]     tx_data,
  output logic             rdata_en,
  input  logic [W-1:0]     rx_data,
  input  logic             rx_valid,
  output logic [CNT_W-1:0] correct_cnt,
  output logic             done,
  output logic             error
);
  import lbtg_pkg::*;

  localparam logic [W-1:0] TAPS = W'(4'b1100);
  localparam logic [W-1:0] SEED = W'(1);

  run_state_t st_q, st_d;
  logic       run;
  logic [W-1:0] ref_data;

  always_comb begin
    st_d = st_q;
    if (st_q == ST_WAIT && cal_done) st_d = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_WAIT;
    else        st_q <= st_d;
  end

  assign run = (st_q == ST_RUN);

  lbtg_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_tx_gen (
    .clk(clk), .rst_n(rst_n), .step(run), .state(tx_data)
  );

  lbtg_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_ref_gen (
    .clk(clk), .rst_n(rst_n), .step(rx_valid), .state(ref_data)
  );

  lbtg_rd_align #(.RD_LAT(RD_LAT)) u_align (
    .clk(clk), .rst_n(rst_n), .run(run), .rd_en(rdata_en)
  );

  lbtg_score #(.W(W), .CNT_W(CNT_W), .RUN_LEN(RUN_LEN)) u_score (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .ref_data(ref_data), .cnt(correct_cnt), .err(error), .fin(done)
  );
endmodule

// File: rtl/lbtg_chk.sv
module lbtg_chk #(
  parameter int W       = 4,
  parameter int CNT_W   = 15,
  parameter int RUN_LEN = 32767
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [W-1:0]     tx_data,
  input logic             rdata_en,
  input logic             rx_valid,
  input logic [CNT_W-1:0] correct_cnt,
  input logic             done,
  input logic             error
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  assert_hold_before_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(tx_data));
  assert_never_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_data != '0);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> tx_data == {$past(tx_data[W-2:0]), $past(tx_data[W-1]) ^ $past(tx_data[W-2])});
  assert_rden_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_en |=> rdata_en);
  assert_idle_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(correct_cnt) && $stable(error));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    correct_cnt <= CNT_MAX);
  assert_unit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (correct_cnt == $past(correct_cnt)) || (correct_cnt == $past(correct_cnt) + 1'b1));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  assert_done_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> correct_cnt == CNT_MAX);
endmodule

bind lfsr_loopback_tg lbtg_chk #(.W(W), .CNT_W(CNT_W), .RUN_LEN(RUN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tx_data(tx_data), .rdata_en(rdata_en),
  .rx_valid(rx_valid), .correct_cnt(correct_cnt), .done(done), .error(error)
);

// File: tb/tb_lfsr_loopback_tg.sv
module tb_lfsr_loopback_tg;
  localparam int W       = 4;
  localparam int CNT_W   = 15;
  localparam int RUN_LEN = 120;
  localparam int RD_LAT  = 3;

  logic             clk;
  logic             rst_n;
  logic             cal_done;
  logic [W-1:0]     tx_data;
  logic             rdata_en;
  logic [W-1:0]     rx_data;
  logic             rx_valid;
  logic [CNT_W-1:0] correct_cnt;
  logic             done;
  logic             error;

  int checks, errors, cyc;
  logic [W-1:0] q[$];
  logic [W-1:0] model;
  int  run_idx, deliv;
  bit  started;
  int  exp_cnt;
  bit  exp_err, exp_done;

  lfsr_loopback_tg #(.W(W), .CNT_W(CNT_W), .RUN_LEN(RUN_LEN), .RD_LAT(RD_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .tx_data(tx_data),
    .rdata_en(rdata_en), .rx_data(rx_data), .rx_valid(rx_valid),
    .correct_cnt(correct_cnt), .done(done), .error(error)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W-1:0] nxt(input logic [W-1:0] s);
    return {s[2:0], s[3] ^ s[2]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cal_done = 1'b0; rx_valid = 1'b0; rx_data = '0;
    q.delete(); model = 4'b0001; run_idx = 0; deliv = 0; started = 0;
    exp_cnt = 0; exp_err = 0; exp_done = 0;
    repeat (3) @(negedge clk);
    chk("R1 tx_data in reset", int'(tx_data), 1);
    chk("R1 rdata_en in reset", int'(rdata_en), 0);
    chk("R1 count in reset", int'(correct_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_data after release", int'(tx_data), 1);
    chk("R1 done/error after release", int'({done, error}), 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      cal_done = 1'b0;
      @(negedge clk);
      chk("R2 tx_data held before start", int'(tx_data), 1);
      chk("R4 rdata_en low before start", int'(rdata_en), 0);
    end
  endtask

  task automatic start();
    cal_done = 1'b1;
    @(negedge clk);
    started = 1;
  endtask

  // inj: index of delivered word to corrupt, -1 for none
  task automatic run(input int n, input int inj);
    for (int i = 0; i < n; i++) begin
      chk("R6 correct_cnt", int'(correct_cnt), exp_cnt);
      chk("R7 error", int'(error), int'(exp_err));
      chk("R8 done", int'(done), int'(exp_done));
      if (started) begin
        chk("R3 tx_data sequence", int'(tx_data), int'(model));
        if (tx_data == '0) chk("R3 nonzero", 0, 1);
        chk("R4 rdata_en timing", int'(rdata_en), int'(run_idx >= RD_LAT));
        q.push_back(tx_data);
        model = nxt(model);
        run_idx++;
      end
      exp_done = exp_done | ((exp_cnt == RUN_LEN) && !exp_err);
      cal_done = 1'($urandom_range(0, 1));  // R2: ignored once running
      if (rdata_en && q.size() > 0 && ($urandom_range(0, 3) != 0)) begin
        logic [W-1:0] w, d;
        w = q.pop_front();
        d = (deliv == inj) ? (w ^ 4'b0101) : w;
        deliv++;
        rx_valid = 1'b1;
        rx_data  = d;
        if (d == w) begin
          if (exp_cnt < RUN_LEN) exp_cnt++;
        end else begin
          exp_err = 1'b1;
        end
      end else begin
        rx_valid = 1'b0;
        rx_data  = 4'($urandom);  // R5: ignored when not valid
      end
      @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0;
    void'($urandom(32'd1234));
    do_reset();
    idle(int'($urandom_range(3, 10)));
    start();
    run(600, -1);                       // R6 saturation, R8 done
    chk("R6 saturated at run length", int'(correct_cnt), RUN_LEN);
    chk("R8 done after clean run", int'(done), 1);
    run(40, deliv);                     // R7 late error, R8 done held
    chk("R7 error after late mismatch", int'(error), 1);
    chk("R8 done held after error", int'(done), 1);

    do_reset();
    idle(2);
    start();
    run(400, 10);                       // R7 early error blocks done
    chk("R7 error set", int'(error), 1);
    chk("R8 no done with error", int'(done), 0);

    do_reset();
    start();
    run(30, 0);                         // R7 first word corrupted
    chk("R7 first-word mismatch", int'(error), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule